// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Controller

This block is the control front end of a peripheral. A small register holds two bits: a reset request that drives the peripheral's internal reset, and a clock-off bit that stops the peripheral's clock through an enable output. Software can reach the register at three word addresses. The first replaces the whole value. The second sets only the bits written as 1. The third clears only the bits written as 1. A read at any of the three returns the current value.

A reset works as a handshake. Software sets the reset bit. The controller holds the peripheral in reset for a fixed number of cycles and then sets the clock-off bit by itself. Software polls until that bit reads 1. It then clears the reset bit, waits about a microsecond, clears the clock-off bit, and polls until the clock-off bit reads 0.

Bus accesses at or above the peripheral base address pass through to the peripheral. While the clock is off, writes there are dropped and reads return zero.

Top module: `srcg_top`

## Requirements
- R1: After reset, the control register reads 0 at addresses 0, 1 and 2, `periphRstN` is 1 and `periphClkEn` is 1.
- R2: A write to address 0 replaces the register. Only bit 1 (reset request) and bit 0 (clock off) are stored, and all other bits read as 0.
- R3: A write to address 1 ORs the written bits into the register. A write to address 2 clears the bits written as 1. Reads at addresses 0, 1 and 2 all return the register. Address 3 reads 0, and writes to it change nothing.
- R4: From the cycle after the reset-request bit becomes 1, `periphRstN` is 0 and the peripheral's registers return to their reset values.
- R5: The clock-off bit is set by hardware exactly `HOLD_CYCLES` cycles after the reset-request bit first reads 1, and not earlier. `periphClkEn` drops in the same cycle.
- R6: If the reset-request bit is cleared before the hold completes, the clock-off bit is not set.
- R7: Clearing the reset-request bit through address 2 makes it read 0 in the next cycle and sets `periphRstN` to 1. The clock-off bit keeps its value.
- R8: Clearing the clock-off bit through address 2 makes it read 0 in the next cycle and sets `periphClkEn` to 1.
- R9: While the clock-off bit is 1, accesses at or above `PERIPH_BASE` (4) do not raise `periphWe`, and reads there return 0.
- R10: While the clock-off bit is 0, writes at or above `PERIPH_BASE` raise `periphWe` in the same cycle, and reads there return `periphRdata`.
- R11: The hardware sets the clock-off bit once for each rise of the reset-request bit. Writing the reset request again while it is already 1 does not start a new hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| periphWe | output | 1 | Write strobe to peripheral registers |
| periphAddr | output | ADDR_W | Address to the peripheral |
| periphWdata | output | DATA_W | Write data to the peripheral |
| periphRdata | input | DATA_W | Peripheral read data |
| periphRstN | output | 1 | Active-low reset to the peripheral |
| periphClkEn | output | 1 | Clock enable to the peripheral |

## Verification
The assertions assume at most one bus access per cycle, with the address, data and direction stable for that whole cycle. They also assume that `periphRdata` depends only on `periphAddr` and the peripheral's stored state. The bench drives each access for exactly one cycle and deasserts `busSel` between operations. Its peripheral stub answers reads combinationally from a small register file, which that stub clears whenever `periphRstN` is low. The hold window is checked from a cycle count, read by read, around the expected gating cycle.

// File: rtl/srcg_pkg.sv
package srcg_pkg;
  typedef struct packed {
    logic wrBase;
    logic wrSet;
    logic wrClr;
    logic hwGate;
    logic periphWr;
    logic rdCtrl;
    logic rdPeriph;
  } ctrlStrobes_t;
endpackage

// File: rtl/srcg_ctrl.sv
module srcg_ctrl
  import srcg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int HOLD_CYCLES = 4,
  parameter int PERIPH_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              srstQ,
  input  logic              gateQ,
  output ctrlStrobes_t      strb
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_BASE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_SET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_PER  = ADDR_W'(PERIPH_BASE);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CNT_DONE  = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;
  logic wrAcc, rdAcc, inPeriph;

  // Hold counter: counts cycles with reset requested, saturates once done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  holdCnt <= '0;
    else if (!srstQ)            holdCnt <= '0;
    else if (holdCnt != CNT_DONE) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    wrAcc    = busSel && busWrite;
    rdAcc    = busSel && !busWrite;
    inPeriph = busAddr >= ADDR_PER;
    strb.wrBase   = wrAcc && (busAddr == ADDR_BASE);
    strb.wrSet    = wrAcc && (busAddr == ADDR_SET);
    strb.wrClr    = wrAcc && (busAddr == ADDR_CLR);
    strb.hwGate   = srstQ && (holdCnt == CNT_LAST);
    strb.periphWr = wrAcc && inPeriph && !gateQ;
    strb.rdCtrl   = rdAcc && (busAddr <= ADDR_CLR);
    strb.rdPeriph = rdAcc && inPeriph;
  end
endmodule

// File: rtl/srcg_datapath.sv
module srcg_datapath
  import srcg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SRST_BIT = 1,
  parameter int GATE_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [1:0]        ctrlWbits,   // [1]=clock off, [0]=reset request
  input  logic [DATA_W-1:0] periphRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              srstQ,
  output logic              gateQ
);
  localparam int NBITS = 2;

  logic [NBITS-1:0] qBits, nextBits, hwSet;

  assign hwSet = {strb.hwGate, 1'b0};

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic aliasVal;
    always_comb begin
      if (strb.wrBase)     aliasVal = ctrlWbits[g];
      else if (strb.wrSet) aliasVal = qBits[g] | ctrlWbits[g];
      else if (strb.wrClr) aliasVal = qBits[g] & ~ctrlWbits[g];
      else                 aliasVal = qBits[g];
    end
    // hardware gating wins over a software write in the same cycle
    assign nextBits[g] = aliasVal | hwSet[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qBits <= '0;
    else       qBits <= nextBits;
  end

  assign srstQ = qBits[0];
  assign gateQ = qBits[1];

  always_comb begin
    busRdata = '0;
    if (strb.rdCtrl) begin
      busRdata[SRST_BIT] = srstQ;
      busRdata[GATE_BIT] = gateQ;
    end else if (strb.rdPeriph && !gateQ) begin
      busRdata = periphRdata;
    end
  end
endmodule

// File: rtl/srcg_top.sv
module srcg_top
  import srcg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int HOLD_CYCLES = 4,
  parameter int PERIPH_BASE = 4,
  parameter int SRST_BIT    = 1,
  parameter int GATE_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              periphWe,
  output logic [ADDR_W-1:0] periphAddr,
  output logic [DATA_W-1:0] periphWdata,
  input  logic [DATA_W-1:0] periphRdata,
  output logic              periphRstN,
  output logic              periphClkEn
);
  ctrlStrobes_t strb;
  logic srstQ, gateQ;

  srcg_ctrl #(
    .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES), .PERIPH_BASE(PERIPH_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .srstQ(srstQ), .gateQ(gateQ), .strb(strb)
  );

  srcg_datapath #(
    .DATA_W(DATA_W), .SRST_BIT(SRST_BIT), .GATE_BIT(GATE_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ctrlWbits({busWdata[GATE_BIT], busWdata[SRST_BIT]}),
    .periphRdata(periphRdata), .busRdata(busRdata),
    .srstQ(srstQ), .gateQ(gateQ)
  );

  assign periphWe    = strb.periphWr;
  assign periphAddr  = busAddr;
  assign periphWdata = busWdata;
  assign periphRstN  = !srstQ;
  assign periphClkEn = !gateQ;
endmodule

// File: rtl/srcg_checker.sv
module srcg_checker #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int HOLD_CYCLES = 4,
  parameter int PERIPH_BASE = 4,
  parameter int SRST_BIT    = 1,
  parameter int GATE_BIT    = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              periphWe,
  input logic              periphRstN,
  input logic              periphClkEn,
  input logic              srstQ,
  input logic              gateQ
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] chkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chkCnt <= '0;
    else if (!srstQ)       chkCnt <= '0;
    else if (chkCnt != DONE) chkCnt <= chkCnt + 1'b1;
  end

  logic wr, inPer, holdEnd, swGateSet, clrSrst, setSrst, clrGate;
  assign wr        = busSel && busWrite;
  assign inPer     = busAddr >= ADDR_W'(PERIPH_BASE);
  assign holdEnd   = srstQ && (chkCnt == LAST);
  assign swGateSet = wr && (busAddr == ADDR_W'(0) || busAddr == ADDR_W'(1)) && busWdata[GATE_BIT];
  assign setSrst   = wr && (busAddr == ADDR_W'(1)) && busWdata[SRST_BIT];
  assign clrSrst   = wr && (busAddr == ADDR_W'(2)) && busWdata[SRST_BIT];
  assign clrGate   = wr && (busAddr == ADDR_W'(2)) && busWdata[GATE_BIT];

  AST_SET_HOLDS_RST: assert property (@(posedge clk) disable iff (!rstN) setSrst |=> !periphRstN); // R4
  AST_GATE_AT_HOLD_END: assert property (@(posedge clk) disable iff (!rstN) holdEnd |=> (gateQ && !periphClkEn)); // R5
  AST_NO_EARLY_GATE: assert property (@(posedge clk) disable iff (!rstN) $rose(gateQ) |-> $past(swGateSet || holdEnd)); // R5
  AST_CLR_RELEASES_RST: assert property (@(posedge clk) disable iff (!rstN) clrSrst |=> (periphRstN && !srstQ)); // R7
  AST_CLR_UNGATES: assert property (@(posedge clk) disable iff (!rstN) (clrGate && !holdEnd) |=> periphClkEn); // R8
  AST_GATED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) gateQ |-> !periphWe); // R9
  AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN) (gateQ && busSel && !busWrite && inPer) |-> (busRdata == '0)); // R9
endmodule

bind srcg_top srcg_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES),
  .PERIPH_BASE(PERIPH_BASE), .SRST_BIT(SRST_BIT), .GATE_BIT(GATE_BIT)
) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .periphWe(periphWe), .periphRstN(periphRstN), .periphClkEn(periphClkEn),
  .srstQ(srstQ), .gateQ(gateQ)
);

// File: tb/srcg_top_tb_top.sv
`timescale 1ns/1ps
module srcg_top_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int HOLD = 4;
  localparam logic [31:0] SR = 32'h2;
  localparam logic [31:0] GT = 32'h1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata, periphWdata, periphRdata;
  logic [AW-1:0] periphAddr;
  logic periphWe, periphRstN, periphClkEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  srcg_top #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periphWe(periphWe), .periphAddr(periphAddr), .periphWdata(periphWdata),
    .periphRdata(periphRdata), .periphRstN(periphRstN), .periphClkEn(periphClkEn)
  );

  // Peripheral stub: four registers, cleared while held in reset
  logic [DW-1:0] stubRegs [4];
  always @(posedge clk) begin
    if (!rstN || !periphRstN) begin
      for (int i = 0; i < 4; i++) stubRegs[i] <= '0;
    end else if (periphWe && periphClkEn) begin
      stubRegs[periphAddr[1:0]] <= periphWdata;
    end
  end
  assign periphRdata = stubRegs[periphAddr[1:0]];

  typedef struct {
    logic [DW-1:0] data;
    logic          rstN;
    logic          clkEn;
    string         tag;
  } expItem_t;
  expItem_t sbQ[$];

  // Monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (busSel && !busWrite) begin
      expItem_t e;
      checks++;
      if (sbQ.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expectation, actual %h expected none", busRdata);
      end else begin
        e = sbQ.pop_front();
        if (busRdata !== e.data || periphRstN !== e.rstN || periphClkEn !== e.clkEn) begin
          fails++;
          $display("FAIL %s: actual data=%h rstN=%b clkEn=%b expected data=%h rstN=%b clkEn=%b",
                   e.tag, busRdata, periphRstN, periphClkEn, e.data, e.rstN, e.clkEn);
        end
      end
    end
  end

  // Tasks start at posedge+1 and return at the next posedge+1
  task automatic busRead(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic r, input logic c, input string tag);
    expItem_t e;
    e.data = d; e.rstN = r; e.clkEn = c; e.tag = tag;
    sbQ.push_back(e);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic periphWr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic expWe, input string tag);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    #1;
    checks++;
    if (periphWe !== expWe) begin
      fails++;
      $display("FAIL %s: periphWe actual %b expected %b", tag, periphWe, expWe);
    end
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Set reset request and watch the hold window, then the gate
  task automatic resetSeq(input string tag);
    busWr(1, SR);
    for (int k = 1; k < HOLD; k++) busRead(0, SR, 1'b0, 1'b1, tag);
    busRead(0, SR, 1'b0, 1'b1, {tag, " last hold cycle"});
    busRead(0, SR | GT, 1'b0, 1'b0, {tag, " gate set"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    busRead(0, 0, 1'b1, 1'b1, "R1 base");
    busRead(1, 0, 1'b1, 1'b1, "R1 set alias");
    busRead(2, 0, 1'b1, 1'b1, "R1 clr alias");
    // R2 base replaces, unused bits read 0
    busWr(0, 32'hFFFF_FFFC); busRead(0, 0, 1'b1, 1'b1, "R2 unused bits");
    busWr(0, GT);            busRead(0, GT, 1'b1, 1'b0, "R2 base write");
    busWr(0, 0);             busRead(0, 0, 1'b1, 1'b1, "R2 base clear");
    // R3 set/clear aliases and reserved address
    busWr(1, GT); busRead(1, GT, 1'b1, 1'b0, "R3 set ORs");
    busWr(1, 0);  busRead(2, GT, 1'b1, 1'b0, "R3 set zero no effect");
    busWr(2, 0);  busRead(0, GT, 1'b1, 1'b0, "R3 clr zero no effect");
    busWr(2, GT); busRead(0, 0, 1'b1, 1'b1, "R3 clr clears");
    busWr(3, 32'hFFFF_FFFF);
    busRead(3, 0, 1'b1, 1'b1, "R3 reserved reads 0");
    busRead(0, 0, 1'b1, 1'b1, "R3 reserved write ignored");
    // R10 forwarding while clock runs
    periphWr(4, 32'hA5, 1'b1, "R10 write strobe");
    periphWr(5, 32'h5A, 1'b1, "R10 write strobe 2");
    busRead(4, 32'hA5, 1'b1, 1'b1, "R10 read forwarded");
    busRead(5, 32'h5A, 1'b1, 1'b1, "R10 read forwarded 2");
    // R9 gated accesses
    busWr(0, GT);
    periphWr(4, 32'h33, 1'b0, "R9 gated write dropped");
    busRead(4, 0, 1'b1, 1'b0, "R9 gated read zero");
    busWr(2, GT);
    busRead(4, 32'hA5, 1'b1, 1'b1, "R9 write had no effect");
    // R4 R5 hold then hardware gate
    resetSeq("R5 R4 hold window");
    // R11 re-set while set; software clears gate, no re-gate
    busWr(1, SR); busRead(0, SR | GT, 1'b0, 1'b0, "R11 re-set no change");
    busWr(2, GT); busRead(0, SR, 1'b0, 1'b1, "R11 gate cleared in reset");
    idle(HOLD + 2);
    busRead(0, SR, 1'b0, 1'b1, "R11 no second gating");
    busWr(1, SR); idle(HOLD + 2);
    busRead(0, SR, 1'b0, 1'b1, "R11 no restart");
    busWr(2, SR); busRead(0, 0, 1'b1, 1'b1, "R11 exit");
    // Full handshake: R7 then R8, R4 peripheral cleared
    periphWr(6, 32'h77, 1'b1, "R10 preload");
    resetSeq("R5 second sequence");
    busWr(2, SR); busRead(0, GT, 1'b1, 1'b0, "R7 reset released, gate kept");
    busRead(6, 0, 1'b1, 1'b0, "R9 gated after reset");
    busWr(2, GT); busRead(0, 0, 1'b1, 1'b1, "R8 ungated");
    busRead(6, 0, 1'b1, 1'b1, "R4 peripheral state cleared");
    busRead(4, 0, 1'b1, 1'b1, "R4 peripheral state cleared 2");
    // R6 cancel before hold completes
    busWr(1, SR);
    busRead(0, SR, 1'b0, 1'b1, "R6 in hold");
    busWr(2, SR);
    for (int k = 0; k < HOLD + 2; k++) busRead(0, 0, 1'b1, 1'b1, "R6 cancelled no gate");
    idle(3);
    if (sbQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", sbQ.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule